// File: doc/BRIEF.md
# Grouped Sector Erase Sequencer

This block erases a contiguous run of flash sectors on behalf of a host. The host gives the index of the first and of the last sector together with a protect vector holding one bit per sector, then pulses start. The block checks the range. It then works through the range in groups of up to three sectors. For each group it sends the five-write unlock and erase-setup preamble once. It marks every unprotected sector of the group with a sector-erase command. It waits a minimum settle time, and then polls the status word of the last sector it marked until the ready bit is set.

Sectors whose protect bit is set get no command. A group in which every sector is protected ends the whole operation early after a single read-mode restore write. A poll that runs past the erase time limit ends the operation with a timeout code. The flash side is a simple synchronous master: one request held until acknowledged, for each read or write.

Top module: `sector_erase_sequencer`

## Requirements
- R1: A start is rejected when first is negative, when first exceeds last, or when last is not below NUM_SECT (indices are two's complement). On rejection `done_o` pulses one cycle after start, `err_o` reads 1, and no bus request is made.
- R2: Every group opens with five writes to the bank base plus an offset, in this order: 0xAA at +0x555, 0x55 at +0x2AA, 0x80 at +0x555, 0xAA at +0x555, 0x55 at +0x2AA.
- R3: After the preamble, up to three consecutive indices starting at the group's first index are examined, never going past last. Each unprotected one gets 0x30 written at BANK_BASE + (index << SECT_SHIFT). Protected ones get no access.
- R4: The first status read of a group starts no fewer than SETUP_CYC cycles after the acknowledge of that group's last mark write.
- R5: Status reads address the last sector marked in the group and repeat until bit 7 of the read data is 1.
- R6: A group whose poll succeeds ends with 0xF0 written to the bank base, and the index advances by the number of indices examined. When the index passes last, one more 0xF0 write is made and `done_o` pulses with `err_o` = 0.
- R7: A group in which no sector was marked still waits the settle time. It then makes a single 0xF0 write to the bank base and ends the operation with `err_o` = 0, skipping any later groups.
- R8: If a poll completes with bit 7 clear after TMO_CYC cycles of polling, the operation ends with `err_o` = 2 and no further bus access.
- R9: For an accepted request `prot_cnt_o` gives the number of protected sectors inside [first, last]. For a rejected request it reads 0.
- R10: Once `bus_req_o` is raised it stays high with stable address, data and direction until `bus_ack_i`. Each acknowledge completes exactly one access.
- R11: A start pulse while the block is busy has no effect on the operation in progress.
- R12: After reset the block is idle: `busy_o`, `done_o` and `bus_req_o` are 0, and `err_o` and `prot_cnt_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse, sampled while idle |
| first_i | input | clog2(NUM_SECT)+2 | First sector index, two's complement |
| last_i | input | clog2(NUM_SECT)+2 | Last sector index, two's complement |
| protect_i | input | NUM_SECT | Per-sector protect bits, sampled at start |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 2 | Result: 0 ok, 1 bad range, 2 timeout |
| prot_cnt_o | output | clog2(NUM_SECT+1) | Protected sectors in the accepted range |
| bus_req_o | output | 1 | Flash access request |
| bus_we_o | output | 1 | 1 write, 0 read |
| bus_addr_o | output | ADDR_W | Flash word address |
| bus_wdata_o | output | DATA_W | Write data |
| bus_rdata_i | input | DATA_W | Read data, valid with acknowledge |
| bus_ack_i | input | 1 | Access acknowledge |

## Verification
A rejected start is due on `done_o` and `err_o` exactly one cycle after the start edge, so the bench samples at the first falling edge after start. Each flash access completes on the edge that sees its acknowledge. The next request rises one cycle later, and the bench's responder logs every write with its cycle number at the falling edge where it grants the acknowledge. The settle window is checked by comparing the cycle of the first status read with the cycle of the last mark write, against SETUP_CYC. Results that depend on latency, such as the final code, the protected count and the write sequence, are checked only after `done_o` is seen, so random acknowledge delays do not move the sample points.

// File: rtl/esq_pkg.sv
package esq_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_UNLOCK,
    S_MARK,
    S_SETTLE,
    S_POLL,
    S_GRP_RST,
    S_END_RST
  } esq_state_e;

  localparam logic [1:0] ERR_NONE  = 2'd0;
  localparam logic [1:0] ERR_RANGE = 2'd1;
  localparam logic [1:0] ERR_TMO   = 2'd2;

  localparam logic [7:0] CMD_SECT_ERASE = 8'h30;
  localparam logic [7:0] CMD_READ_MODE  = 8'hF0;
  localparam logic [2:0] UNLOCK_LAST    = 3'd4;

  // preamble word offsets from the bank base, step 0..4
  function automatic logic [11:0] unlock_off(input logic [2:0] step);
    case (step)
      3'd1, 3'd4: unlock_off = 12'h2AA;
      default:    unlock_off = 12'h555;
    endcase
  endfunction

  // preamble data bytes, step 0..4
  function automatic logic [7:0] unlock_dat(input logic [2:0] step);
    case (step)
      3'd0, 3'd3: unlock_dat = 8'hAA;
      3'd1, 3'd4: unlock_dat = 8'h55;
      default:    unlock_dat = 8'h80;
    endcase
  endfunction

endpackage

// File: rtl/esq_range_check.sv
module esq_range_check #(
  parameter int NUM_SECT = 16,
  parameter int SIW      = 6,
  parameter int CNT_W    = 5
) (
  input  logic [SIW-1:0]      first_i,
  input  logic [SIW-1:0]      last_i,
  input  logic [NUM_SECT-1:0] protect_i,
  output logic                valid_o,
  output logic [CNT_W-1:0]    count_o
);

  localparam logic signed [SIW-1:0] TOP_IDX = SIW'(NUM_SECT - 1);

  logic signed [SIW-1:0] f_s;
  logic signed [SIW-1:0] l_s;
  logic [NUM_SECT-1:0]   in_rng;

  assign f_s = $signed(first_i);
  assign l_s = $signed(last_i);

  assign valid_o = (f_s >= 0) && (f_s <= l_s) && (l_s <= TOP_IDX);

  for (genvar g = 0; g < NUM_SECT; g++) begin : g_win
    localparam logic signed [SIW-1:0] GI = SIW'(g);
    assign in_rng[g] = (f_s <= GI) && (GI <= l_s) && protect_i[g];
  end

  always_comb begin
    count_o = '0;
    for (int i = 0; i < NUM_SECT; i++) begin
      count_o = count_o + CNT_W'(in_rng[i]);
    end
  end

endmodule

// File: rtl/esq_bus_port.sv
module esq_bus_port #(
  parameter int AW = 24,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid_i,
  input  logic          cmd_we_i,
  input  logic [AW-1:0] cmd_addr_i,
  input  logic [DW-1:0] cmd_data_i,
  output logic          cmd_done_o,
  output logic          bus_req_o,
  output logic          bus_we_o,
  output logic [AW-1:0] bus_addr_o,
  output logic [DW-1:0] bus_wdata_o,
  input  logic          bus_ack_i
);

  logic          req_q, req_d;
  logic          we_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] data_q;
  logic          launch;

  assign launch     = cmd_valid_i & ~req_q;
  assign cmd_done_o = req_q & bus_ack_i;

  always_comb begin
    req_d = req_q;
    if (launch)          req_d = 1'b1;
    else if (cmd_done_o) req_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q  <= 1'b0;
      we_q   <= 1'b0;
      addr_q <= '0;
      data_q <= '0;
    end else begin
      req_q <= req_d;
      if (launch) begin
        we_q   <= cmd_we_i;
        addr_q <= cmd_addr_i;
        data_q <= cmd_data_i;
      end
    end
  end

  assign bus_req_o   = req_q;
  assign bus_we_o    = we_q;
  assign bus_addr_o  = addr_q;
  assign bus_wdata_o = data_q;

endmodule

// File: rtl/esq_timer.sv
module esq_timer #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic         expired_o
);

  logic [W-1:0] cnt_q, cnt_d;
  logic         cnt_en;

  assign cnt_en = load_i | (cnt_q != '0);

  always_comb begin
    if (load_i) cnt_d = val_i;
    else        cnt_d = cnt_q - W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign expired_o = (cnt_q == '0);

endmodule

// File: rtl/sector_erase_sequencer.sv
module sector_erase_sequencer #(
  parameter int                NUM_SECT   = 16,
  parameter int                ADDR_W     = 24,
  parameter int                DATA_W     = 16,
  parameter int                SECT_SHIFT = 16,
  parameter logic [ADDR_W-1:0] BANK_BASE  = '0,
  parameter int                GROUP_MAX  = 3,
  parameter int                SETUP_CYC  = 20000,
  parameter int                TMO_CYC    = 2500000
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            start_i,
  input  logic [$clog2(NUM_SECT)+1:0]     first_i,
  input  logic [$clog2(NUM_SECT)+1:0]     last_i,
  input  logic [NUM_SECT-1:0]             protect_i,
  output logic                            busy_o,
  output logic                            done_o,
  output logic [1:0]                      err_o,
  output logic [$clog2(NUM_SECT+1)-1:0]   prot_cnt_o,
  output logic                            bus_req_o,
  output logic                            bus_we_o,
  output logic [ADDR_W-1:0]               bus_addr_o,
  output logic [DATA_W-1:0]               bus_wdata_o,
  input  logic [DATA_W-1:0]               bus_rdata_i,
  input  logic                            bus_ack_i
);
  import esq_pkg::*;

  localparam int IDX_W  = $clog2(NUM_SECT);
  localparam int SIW    = IDX_W + 2;
  localparam int CNT_W  = $clog2(NUM_SECT + 1);
  localparam int GW     = $clog2(GROUP_MAX + 1);
  localparam int TMAX   = (SETUP_CYC > TMO_CYC) ? SETUP_CYC : TMO_CYC;
  localparam int TMR_W  = $clog2(TMAX + 1);
  localparam int RDY_BIT = 7;

  // state
  esq_state_e            st_q, st_d;
  logic [SIW-1:0]        sect_q, sect_d;
  logic [SIW-1:0]        last_q, last_d;
  logic [NUM_SECT-1:0]   prot_q, prot_d;
  logic [2:0]            step_q, step_d;
  logic [GW-1:0]         ss_q, ss_d;
  logic                  trig_q, trig_d;
  logic [IDX_W-1:0]      ltrig_q, ltrig_d;
  logic [1:0]            err_q, err_d;
  logic                  done_q, done_d;
  logic [CNT_W-1:0]      pc_q, pc_d;

  // datapath links
  logic                  rng_valid;
  logic [CNT_W-1:0]      rng_cnt;
  logic                  cmd_valid, cmd_we, cmd_done;
  logic [ADDR_W-1:0]     cmd_addr;
  logic [DATA_W-1:0]     cmd_data;
  logic                  tmr_load, tmr_exp;
  logic [TMR_W-1:0]      tmr_val;
  logic [SIW-1:0]        cur;
  logic [SIW-1:0]        nxt_sect;
  logic                  unused_rdata;

  assign unused_rdata = &{1'b0, bus_rdata_i};

  function automatic logic [ADDR_W-1:0] sect_addr(input logic [IDX_W-1:0] idx);
    sect_addr = BANK_BASE + (ADDR_W'(idx) << SECT_SHIFT);
  endfunction

  esq_range_check #(
    .NUM_SECT (NUM_SECT),
    .SIW      (SIW),
    .CNT_W    (CNT_W)
  ) u_range (
    .first_i   (first_i),
    .last_i    (last_i),
    .protect_i (protect_i),
    .valid_o   (rng_valid),
    .count_o   (rng_cnt)
  );

  esq_bus_port #(
    .AW (ADDR_W),
    .DW (DATA_W)
  ) u_port (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_valid_i (cmd_valid),
    .cmd_we_i    (cmd_we),
    .cmd_addr_i  (cmd_addr),
    .cmd_data_i  (cmd_data),
    .cmd_done_o  (cmd_done),
    .bus_req_o   (bus_req_o),
    .bus_we_o    (bus_we_o),
    .bus_addr_o  (bus_addr_o),
    .bus_wdata_o (bus_wdata_o),
    .bus_ack_i   (bus_ack_i)
  );

  esq_timer #(
    .W (TMR_W)
  ) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_i    (tmr_load),
    .val_i     (tmr_val),
    .expired_o (tmr_exp)
  );

  assign cur      = sect_q + SIW'(ss_q);
  assign nxt_sect = sect_q + SIW'(ss_q);

  // next-state logic
  always_comb begin
    st_d      = st_q;
    sect_d    = sect_q;
    last_d    = last_q;
    prot_d    = prot_q;
    step_d    = step_q;
    ss_d      = ss_q;
    trig_d    = trig_q;
    ltrig_d   = ltrig_q;
    err_d     = err_q;
    pc_d      = pc_q;
    done_d    = 1'b0;
    cmd_valid = 1'b0;
    cmd_we    = 1'b1;
    cmd_addr  = BANK_BASE;
    cmd_data  = '0;
    tmr_load  = 1'b0;
    tmr_val   = '0;

    case (st_q)
      S_IDLE: begin
        if (start_i) begin
          if (!rng_valid) begin
            err_d  = ERR_RANGE;
            pc_d   = '0;
            done_d = 1'b1;
          end else begin
            err_d  = ERR_NONE;
            pc_d   = rng_cnt;
            sect_d = first_i;
            last_d = last_i;
            prot_d = protect_i;
            step_d = '0;
            st_d   = S_UNLOCK;
          end
        end
      end

      S_UNLOCK: begin
        cmd_valid = 1'b1;
        cmd_addr  = BANK_BASE + ADDR_W'(unlock_off(step_q));
        cmd_data  = DATA_W'(unlock_dat(step_q));
        if (cmd_done) begin
          if (step_q == UNLOCK_LAST) begin
            step_d = '0;
            ss_d   = '0;
            trig_d = 1'b0;
            st_d   = S_MARK;
          end else begin
            step_d = step_q + 3'd1;
          end
        end
      end

      S_MARK: begin
        if ((ss_q == GW'(GROUP_MAX)) || ($signed(cur) > $signed(last_q))) begin
          tmr_load = 1'b1;
          tmr_val  = TMR_W'(SETUP_CYC);
          st_d     = S_SETTLE;
        end else if (prot_q[cur[IDX_W-1:0]]) begin
          ss_d = ss_q + GW'(1);
        end else begin
          cmd_valid = 1'b1;
          cmd_addr  = sect_addr(cur[IDX_W-1:0]);
          cmd_data  = DATA_W'(CMD_SECT_ERASE);
          if (cmd_done) begin
            trig_d  = 1'b1;
            ltrig_d = cur[IDX_W-1:0];
            ss_d    = ss_q + GW'(1);
          end
        end
      end

      S_SETTLE: begin
        if (tmr_exp) begin
          if (trig_q) begin
            tmr_load = 1'b1;
            tmr_val  = TMR_W'(TMO_CYC);
            st_d     = S_POLL;
          end else begin
            st_d = S_END_RST;
          end
        end
      end

      S_POLL: begin
        cmd_valid = 1'b1;
        cmd_we    = 1'b0;
        cmd_addr  = sect_addr(ltrig_q);
        if (cmd_done) begin
          if (bus_rdata_i[RDY_BIT]) begin
            st_d = S_GRP_RST;
          end else if (tmr_exp) begin
            err_d  = ERR_TMO;
            done_d = 1'b1;
            st_d   = S_IDLE;
          end
        end
      end

      S_GRP_RST: begin
        cmd_valid = 1'b1;
        cmd_data  = DATA_W'(CMD_READ_MODE);
        if (cmd_done) begin
          sect_d = nxt_sect;
          step_d = '0;
          st_d   = ($signed(nxt_sect) > $signed(last_q)) ? S_END_RST : S_UNLOCK;
        end
      end

      S_END_RST: begin
        cmd_valid = 1'b1;
        cmd_data  = DATA_W'(CMD_READ_MODE);
        if (cmd_done) begin
          done_d = 1'b1;
          st_d   = S_IDLE;
        end
      end

      default: st_d = S_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= S_IDLE;
      sect_q  <= '0;
      last_q  <= '0;
      prot_q  <= '0;
      step_q  <= '0;
      ss_q    <= '0;
      trig_q  <= 1'b0;
      ltrig_q <= '0;
      err_q   <= ERR_NONE;
      done_q  <= 1'b0;
      pc_q    <= '0;
    end else begin
      st_q    <= st_d;
      sect_q  <= sect_d;
      last_q  <= last_d;
      prot_q  <= prot_d;
      step_q  <= step_d;
      ss_q    <= ss_d;
      trig_q  <= trig_d;
      ltrig_q <= ltrig_d;
      err_q   <= err_d;
      done_q  <= done_d;
      pc_q    <= pc_d;
    end
  end

  assign busy_o     = (st_q != S_IDLE);
  assign done_o     = done_q;
  assign err_o      = err_q;
  assign prot_cnt_o = pc_q;

endmodule

// File: rtl/esq_checks.sv
module esq_checks #(
  parameter int NUM_SECT = 16,
  parameter int SIW      = 6,
  parameter int AW       = 24,
  parameter int DW       = 16
) (
  input logic           clk,
  input logic           rst_n,
  input logic           start_i,
  input logic [SIW-1:0] first_i,
  input logic [SIW-1:0] last_i,
  input logic           busy_o,
  input logic           done_o,
  input logic [1:0]     err_o,
  input logic           bus_req_o,
  input logic           bus_we_o,
  input logic [AW-1:0]  bus_addr_o,
  input logic [DW-1:0]  bus_wdata_o,
  input logic           bus_ack_i
);

  localparam logic signed [SIW-1:0] TOP_IDX = SIW'(NUM_SECT - 1);

  p_req_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req_o && !bus_ack_i) |=> (bus_req_o && $stable(bus_addr_o) &&
                                   $stable(bus_wdata_o) && $stable(bus_we_o)));

  p_idle_no_bus_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> !bus_req_o);

  p_neg_first_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o && $signed(first_i) < 0) |=> (done_o && err_o == 2'd1 && !busy_o));

  p_reversed_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o && $signed(first_i) > $signed(last_i)) |=> (done_o && err_o == 2'd1));

  p_accept_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o && $signed(first_i) >= 0 && $signed(first_i) <= $signed(last_i) &&
     $signed(last_i) <= TOP_IDX) |=> (busy_o && !done_o));

  p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  p_done_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o);

endmodule

bind sector_erase_sequencer esq_checks #(
  .NUM_SECT (NUM_SECT),
  .SIW      ($clog2(NUM_SECT) + 2),
  .AW       (ADDR_W),
  .DW       (DATA_W)
) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .start_i     (start_i),
  .first_i     (first_i),
  .last_i      (last_i),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .err_o       (err_o),
  .bus_req_o   (bus_req_o),
  .bus_we_o    (bus_we_o),
  .bus_addr_o  (bus_addr_o),
  .bus_wdata_o (bus_wdata_o),
  .bus_ack_i   (bus_ack_i)
);

// File: tb/sector_erase_sequencer_tb_top.sv
`timescale 1ns/1ps
module sector_erase_sequencer_tb_top;

  localparam int NS    = 16;
  localparam int SIW   = $clog2(NS) + 2;
  localparam int CW    = $clog2(NS + 1);
  localparam int AW    = 24;
  localparam int DW    = 16;
  localparam int SETUP = 12;
  localparam int TMO   = 60;
  localparam int LOGN  = 256;

  logic          clk;
  logic          rst_n;
  logic          start_i;
  logic [SIW-1:0] first_i, last_i;
  logic [NS-1:0] protect_i;
  logic          busy_o, done_o;
  logic [1:0]    err_o;
  logic [CW-1:0] prot_cnt_o;
  logic          bus_req_o, bus_we_o;
  logic [AW-1:0] bus_addr_o;
  logic [DW-1:0] bus_wdata_o;
  logic [DW-1:0] bus_rdata_i;
  logic          bus_ack_i;

  sector_erase_sequencer #(
    .NUM_SECT   (NS),
    .ADDR_W     (AW),
    .DATA_W     (DW),
    .SECT_SHIFT (16),
    .BANK_BASE  ('0),
    .GROUP_MAX  (3),
    .SETUP_CYC  (SETUP),
    .TMO_CYC    (TMO)
  ) dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .first_i     (first_i),
    .last_i      (last_i),
    .protect_i   (protect_i),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .err_o       (err_o),
    .prot_cnt_o  (prot_cnt_o),
    .bus_req_o   (bus_req_o),
    .bus_we_o    (bus_we_o),
    .bus_addr_o  (bus_addr_o),
    .bus_wdata_o (bus_wdata_o),
    .bus_rdata_i (bus_rdata_i),
    .bus_ack_i   (bus_ack_i)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit finished = 0;

  // write log from the responder, expected log from the model
  logic [AW-1:0] wr_a [LOGN];
  logic [DW-1:0] wr_d [LOGN];
  int            wr_n;
  logic [AW-1:0] ex_a [LOGN];
  logic [DW-1:0] ex_d [LOGN];
  int            ex_n;
  int            ex_err;
  int            ex_pc;

  int            poll_need;
  int            polls;
  int            lat;
  int            mark_cyc;
  bit            mark_pending;
  logic [AW-1:0] mark_addr;

  initial clk = 1'b0;
  always #2 clk = ~clk;

  initial forever begin
    @(posedge clk);
    cyc++;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  // flash responder: grants acknowledges at falling edges
  initial begin
    bus_ack_i   = 1'b0;
    bus_rdata_i = '0;
    lat         = 0;
    forever begin
      @(negedge clk);
      if (bus_ack_i) begin
        bus_ack_i = 1'b0;
      end else if (bus_req_o) begin
        if (lat == 0) begin
          lat = int'($urandom % 3);
          bus_ack_i = 1'b1;
          if (bus_we_o) begin
            if (wr_n < LOGN) begin
              wr_a[wr_n] = bus_addr_o;
              wr_d[wr_n] = bus_wdata_o;
            end
            wr_n++;
            if (bus_wdata_o == 16'h0030) begin
              mark_cyc     = cyc;
              mark_pending = 1;
              mark_addr    = bus_addr_o;
              polls        = 0;
            end
          end else begin
            // R5: status read goes to the last marked sector
            chk(bus_addr_o == mark_addr, "R5 poll address", int'(bus_addr_o), int'(mark_addr));
            if (mark_pending) begin
              // R4: settle time before the first status read
              chk((cyc - mark_cyc) >= SETUP, "R4 settle gap", cyc - mark_cyc, SETUP);
              mark_pending = 0;
            end
            polls++;
            bus_rdata_i = (polls >= poll_need) ? 16'h0080 : 16'h0000;
          end
        end else begin
          lat--;
        end
      end
    end
  end

  task automatic push(input int a, input int d);
    if (ex_n < LOGN) begin
      ex_a[ex_n] = AW'(a);
      ex_d[ex_n] = DW'(d);
    end
    ex_n++;
  endtask

  // expected write list from the requirements
  task automatic build_exp(input int f, input int l, input logic [NS-1:0] p, input bit tmo);
    int s;
    int lt;
    int ss;
    ex_n = 0;
    if (f < 0 || f > l || l >= NS) begin
      ex_err = 1;
      ex_pc  = 0;
      return;
    end
    ex_err = 0;
    ex_pc  = 0;
    for (int i = f; i <= l; i++) if (p[i]) ex_pc++;
    s = f;
    while (1) begin
      push(16'h555, 8'hAA); push(16'h2AA, 8'h55); push(16'h555, 8'h80);
      push(16'h555, 8'hAA); push(16'h2AA, 8'h55);
      lt = -1;
      ss = 0;
      while (ss < 3 && s + ss <= l) begin
        if (!p[s + ss]) begin
          push((s + ss) << 16, 8'h30);
          lt = s + ss;
        end
        ss++;
      end
      if (lt < 0) begin
        push(0, 8'hF0);
        return;
      end
      if (tmo) begin
        ex_err = 2;
        return;
      end
      push(0, 8'hF0);
      s += ss;
      if (s > l) begin
        push(0, 8'hF0);
        return;
      end
    end
  endtask

  task automatic run_op(input int f, input int l, input logic [NS-1:0] p,
                        input int pn, input bit tmo, input bit poke, input string tag);
    int k;
    bit same;
    build_exp(f, l, p, tmo);
    @(negedge clk);
    wr_n         = 0;
    poll_need    = pn;
    mark_pending = 0;
    first_i      = SIW'(f);
    last_i       = SIW'(l);
    protect_i    = p;
    start_i      = 1'b1;
    @(negedge clk);
    start_i      = 1'b0;
    k = 0;
    if (poke && !done_o) begin
      repeat (3) @(negedge clk);
      first_i   = SIW'(0);
      last_i    = SIW'(NS - 1);
      protect_i = '0;
      start_i   = 1'b1;
      @(negedge clk);
      start_i   = 1'b0;
      k = 4;
    end
    while (!done_o && k < 20000) begin
      @(negedge clk);
      k++;
    end
    chk(done_o == 1'b1, {tag, " done seen"}, int'(done_o), 1);
    if (ex_err == 1) begin
      // R1: rejection answered one cycle after start
      chk(k == 0, "R1 reject latency", k, 0);
    end
    chk(int'(err_o) == ex_err, {tag, " result code"}, int'(err_o), ex_err);
    chk(int'(prot_cnt_o) == ex_pc, "R9 protected count", int'(prot_cnt_o), ex_pc);
    chk(wr_n == ex_n, {tag, " write count"}, wr_n, ex_n);
    same = (wr_n == ex_n);
    for (int i = 0; i < ex_n && i < LOGN && same; i++) begin
      if (wr_a[i] != ex_a[i] || wr_d[i] != ex_d[i]) begin
        same = 0;
        chk(0, {tag, " write sequence"}, int'({wr_a[i], wr_d[i][7:0]}),
            int'({ex_a[i], ex_d[i][7:0]}));
      end
    end
    repeat (2) @(negedge clk);
    chk(!busy_o && !bus_req_o, {tag, " idle after"}, int'(busy_o), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    void'($urandom(32'd2024));
    rst_n     = 1'b0;
    start_i   = 1'b0;
    first_i   = '0;
    last_i    = '0;
    protect_i = '0;
    wr_n      = 0;
    polls     = 0;
    poll_need = 1;
    mark_cyc  = 0;
    mark_pending = 0;
    mark_addr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R12 reset state
    chk(!busy_o && !done_o && !bus_req_o, "R12 idle after reset", int'({busy_o, done_o, bus_req_o}), 0);
    chk(err_o == 2'd0 && prot_cnt_o == '0, "R12 status after reset", int'({err_o, prot_cnt_o}), 0);

    // directed corners
    run_op(0, 0, 16'h0000, 1, 0, 0, "R2 R6 single sector");
    run_op(3, 5, 16'h0000, 3, 0, 0, "R3 one full group");
    run_op(2, 9, 16'h0150, 2, 0, 0, "R3 R6 protected mix");
    run_op(4, 10, 16'h0070, 1, 0, 0, "R7 empty group ends");
    run_op(13, 15, 16'h2000, 1, 0, 0, "R6 top sectors");
    run_op(6, 4, 16'h0000, 1, 0, 0, "R1 reversed range");
    run_op(-1, 3, 16'h0000, 1, 0, 0, "R1 negative first");
    run_op(0, NS, 16'h0000, 1, 0, 0, "R1 last too large");
    run_op(1, 4, 16'h0004, 1000000, 1, 0, "R8 poll timeout");
    run_op(0, 5, 16'h0002, 2, 0, 1, "R11 start while busy");

    // constrained random
    for (int n = 0; n < 24; n++) begin
      int f;
      int l;
      logic [NS-1:0] p;
      f = int'($urandom % NS);
      l = f + int'($urandom % 7);
      if (l > NS - 1) l = NS - 1;
      if ($urandom % 8 == 0) l = f - 1;
      p = NS'($urandom & $urandom);
      run_op(f, l, p, 1 + int'($urandom % 4), 0, 0, "R3 R5 R6 random");
    end
    finish_run();
  end

endmodule